// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one down-counting channel of a programmable interval timer. A processor programs it through a byte-wide port. A write to the control register selects one of six output behaviours and a binary or BCD count. Two writes to the count register then supply a 16-bit start value, low byte first. The channel watches a slow counter-clock input and a GATE input, both sampled in the system clock domain. Every falling edge seen on the counter clock is one counting step. The single OUT line makes the waveform that the chosen behaviour defines.

The six behaviours are: an output that rises at terminal count; a gate-triggered, retriggerable one-shot; a divide-by-N rate generator with a one-step low pulse; a square wave that handles odd counts; a strobe started by software; and a strobe started by hardware. The count can be read back at any time, low byte then high byte. A latch command can also freeze a snapshot so that both bytes come from the same instant while counting goes on.

Top module: `pitc_channel`

## Requirements
- R1: After reset OUT is high, no count is loaded, and the count reads back as 0x0000.
- R2: reg_sel=1 addresses the control register and reg_sel=0 addresses the count. In a control byte, bit 7 set means a latch command, and the other bits are then ignored. With bit 7 clear, bits 2:0 hold the mode (codes 6 and 7 act as modes 2 and 3) and bit 3 selects BCD (1) or binary (0). Writing mode 0 drives OUT low, and writing any other mode drives OUT high.
- R3: Mode 0: the first counter-clock falling edge after the high byte is written loads the count N, and OUT stays low. OUT rises on the Nth following edge, when the count reaches zero. It stays high and the count stays at zero until a new count or control word is written.
- R4: In modes 0 and 4, edges that arrive while GATE is low do not change the count.
- R5: Mode 1: once a count is loaded, a rising GATE arms a trigger. The next edge loads N and drives OUT low. OUT returns high N edges later. A new trigger while OUT is low reloads N. Edges without a trigger leave OUT high.
- R6: Mode 2: after the load edge, OUT falls on the (N-1)th edge and rises again on the Nth, when N reloads, repeating every N edges (N>=2). A low GATE drives OUT high by the next system clock and stops counting. A rising GATE reloads N at the next edge.
- R7: Mode 3: OUT is high for ceil(N/2) edges and low for floor(N/2) edges, repeating (N>=2). An odd value takes one extra single decrement while OUT is high. GATE acts as in R6.
- R8: Mode 4: OUT stays high, goes low on the Nth edge after the load edge, and is high again on the next edge.
- R9: Mode 5: counting waits for a rising GATE. The next edge loads N with OUT high. OUT is low on the Nth edge after that and high on the following edge.
- R10: A loaded 0 is the largest count: its first decrement gives 0xFFFF in binary and 0x9999 in BCD. BCD decrements borrow across decimal digits (0x1000 becomes 0x0999).
- R11: A latch command copies the count. Reads return the copy until its high byte has been read, while counting continues. A latch command given while a copy is held is ignored.
- R12: Count bytes are written and read low byte first. A control word returns both byte sequencers to the low byte, so a half-written count is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| rd_en | input | 1 | Read strobe, advances the read byte sequencer |
| reg_sel | input | 1 | 1 = control register, 0 = count register |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte (count or latched copy) |
| tmr_clk | input | 1 | Counter clock; each falling edge is one counting step |
| gate | input | 1 | Gate / trigger input |
| out | output | 1 | Timer output |

## Verification
The bench measures the high and low lengths of the mode 2 and mode 3 waveforms in counter-clock edges. It uses even, odd, minimum and BCD counts, so an off-by-one reload or a missing odd-count adjustment shows up as a wrong phase length. It holds GATE low in mode 0 and reads the count back, which catches a design that keeps counting. It retriggers the one-shot while OUT is low, which catches a design that ignores the trigger, and it checks that the strobe modes pulse for exactly one edge. Other tests load zero in binary and in BCD and cross a BCD digit boundary, read a latched copy after further counting, and write a half count before a control word, which catches missing borrow logic, a latch that follows the live count, and a byte sequencer that is not reset.

// File: rtl/pitc_pkg.sv
// Shared types for the interval counter channel.
// Assumes a byte-wide control word with the layout described in the brief.
package pitc_pkg;
    typedef enum logic [2:0] {
        M_TC_INT    = 3'd0,
        M_ONESHOT   = 3'd1,
        M_RATE      = 3'd2,
        M_SQUARE    = 3'd3,
        M_SW_STROBE = 3'd4,
        M_HW_STROBE = 3'd5
    } mode_t;

    localparam int CW_LATCH_BIT = 7;
    localparam int CW_BCD_BIT   = 3;
endpackage

// File: rtl/pitc_edge.sv
// Edge detector on a signal sampled in the system clock domain.
// RISE picks rising (1) or falling (0) detection. The reset value of the
// history flop is chosen so that reset never reports a false edge.
// Assumes the input is already synchronous to clk.
module pitc_edge #(
    parameter bit RISE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic edge_o
);
    logic prev_q;

    // keep last sampled level
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= RISE;
        else        prev_q <= sig_i;
    end

    if (RISE) begin : g_rise
        assign edge_o = sig_i & ~prev_q;
    end else begin : g_fall
        assign edge_o = ~sig_i & prev_q;
    end
endmodule

// File: rtl/pitc_dec.sv
// One-step decrement in binary or packed BCD.
// Assumes CNT_W is a multiple of 4; a BCD value of all zeros wraps to all nines.
module pitc_dec #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] val_i,
    input  logic             bcd_i,
    output logic [CNT_W-1:0] val_o
);
    localparam int NDIG = CNT_W / 4;
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [NDIG:0]    brw;
    logic [CNT_W-1:0] bcd_res;

    assign brw[0] = 1'b1;

    for (genvar g = 0; g < NDIG; g++) begin : g_dig
        logic [3:0] dig;
        assign dig = val_i[g*4 +: 4];
        assign bcd_res[g*4 +: 4] = !brw[g] ? dig : ((dig == 4'd0) ? 4'd9 : dig - 4'd1);
        assign brw[g+1] = brw[g] && (dig == 4'd0);
    end

    assign val_o = bcd_i ? bcd_res : (val_i - ONE);
endmodule

// File: rtl/pitc_bus.sv
// Processor-side register access: decodes control words, assembles count
// bytes low-first, keeps the latched copy and the read byte sequencer.
// Assumes CNT_W is a whole number of BUS_W-bit bytes and BUS_W >= 8.
module pitc_bus
    import pitc_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic             reg_sel,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rdata,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             cw_wr_o,
    output mode_t            cw_mode_o,
    output logic             cw_bcd_o,
    output logic             ld_o,
    output logic [CNT_W-1:0] ld_val_o
);
    localparam int NBYTE = CNT_W / BUS_W;
    localparam int PW    = (NBYTE > 1) ? $clog2(NBYTE) : 1;
    localparam logic [PW-1:0] LAST = PW'(NBYTE - 1);

    logic [PW-1:0]    wr_ptr, rd_ptr;
    logic [CNT_W-1:0] asm_q, snap_q, rd_src;
    logic             snap_vld;
    logic             latch_cmd, cnt_wr, cnt_rd;
    logic [2:0]       mode_raw;

    assign latch_cmd = wr_en &  reg_sel &  wdata[CW_LATCH_BIT];
    assign cw_wr_o   = wr_en &  reg_sel & ~wdata[CW_LATCH_BIT];
    assign cnt_wr    = wr_en & ~reg_sel;
    assign cnt_rd    = rd_en & ~reg_sel;
    assign mode_raw  = wdata[2:0];
    assign cw_mode_o = mode_t'((mode_raw[2] & mode_raw[1]) ? {1'b0, mode_raw[1:0]} : mode_raw);
    assign cw_bcd_o  = wdata[CW_BCD_BIT];

    // count value as it would stand with this byte merged in
    always_comb begin
        ld_val_o = asm_q;
        ld_val_o[int'(wr_ptr)*BUS_W +: BUS_W] = wdata;
    end
    assign ld_o = cnt_wr && (wr_ptr == LAST);

    // write byte sequencer and assembly register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            asm_q  <= '0;
        end else if (cw_wr_o) begin
            wr_ptr <= '0;
        end else if (cnt_wr) begin
            asm_q  <= ld_val_o;
            wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
        end
    end

    // read byte sequencer and latched copy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr   <= '0;
            snap_q   <= '0;
            snap_vld <= 1'b0;
        end else if (cw_wr_o) begin
            rd_ptr   <= '0;
        end else if (latch_cmd) begin
            rd_ptr <= '0;
            if (!snap_vld) begin
                snap_q   <= cnt_i;
                snap_vld <= 1'b1;
            end
        end else if (cnt_rd) begin
            if (rd_ptr == LAST) begin
                rd_ptr   <= '0;
                snap_vld <= 1'b0;
            end else begin
                rd_ptr <= rd_ptr + 1'b1;
            end
        end
    end

    // read data mux: latched copy wins over the live count
    assign rd_src = snap_vld ? snap_q : cnt_i;
    assign rdata  = reg_sel ? '0 : rd_src[int'(rd_ptr)*BUS_W +: BUS_W];

    // R11: a held copy does not move until its last byte is read
    a_r11_snap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (snap_vld && !(cnt_rd && rd_ptr == LAST)) |=> $stable(snap_q));

    // R12: a control word returns the next count write to the low byte
    a_r12_cw_resets_seq: assert property (@(posedge clk) disable iff (!rst_n)
        cw_wr_o |=> (wr_ptr == '0 && rd_ptr == '0));
endmodule

// File: rtl/pitc_core.sv
// Counting engine: holds mode, reload value and count, and produces OUT
// for the six modes at every counter-clock step.
// Assumes tick_i is a one-cycle pulse per counter-clock falling edge and
// gate_rise_i a one-cycle pulse per rising GATE.
module pitc_core
    import pitc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             gate_i,
    input  logic             gate_rise_i,
    input  logic             cw_wr_i,
    input  mode_t            cw_mode_i,
    input  logic             cw_bcd_i,
    input  logic             ld_i,
    input  logic [CNT_W-1:0] ld_val_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             out_o
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0] TWO = ONE << 1;

    mode_t            mode_q;
    logic             bcd_q, out_q, armed_q, run_q, pend_q, trig_q;
    logic [CNT_W-1:0] reload_q, cnt_q, dec1, dec2, reload_even;
    logic             trig_now, rate_mode, restart_mode;

    pitc_dec #(.CNT_W(CNT_W)) u_dec1 (.val_i(cnt_q), .bcd_i(bcd_q), .val_o(dec1));
    pitc_dec #(.CNT_W(CNT_W)) u_dec2 (.val_i(dec1),  .bcd_i(bcd_q), .val_o(dec2));

    assign trig_now     = trig_q | gate_rise_i;
    assign rate_mode    = (mode_q == M_RATE) || (mode_q == M_SQUARE);
    assign restart_mode = (mode_q != M_ONESHOT) && (mode_q != M_HW_STROBE);
    assign reload_even  = {reload_q[CNT_W-1:1], 1'b0};

    // mode register, count, reload value and output waveform
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= M_TC_INT;
            bcd_q    <= 1'b0;
            reload_q <= '0;
            cnt_q    <= '0;
            out_q    <= 1'b1;
            armed_q  <= 1'b0;
            run_q    <= 1'b0;
            pend_q   <= 1'b0;
            trig_q   <= 1'b0;
        end else if (cw_wr_i) begin
            mode_q  <= cw_mode_i;
            bcd_q   <= cw_bcd_i;
            out_q   <= (cw_mode_i != M_TC_INT);
            armed_q <= 1'b0;
            run_q   <= 1'b0;
            pend_q  <= 1'b0;
            trig_q  <= 1'b0;
        end else begin
            if (gate_rise_i) trig_q <= 1'b1;
            if (tick_i) begin
                trig_q <= 1'b0;
                unique case (mode_q)
                    M_TC_INT, M_SW_STROBE: begin
                        if (mode_q == M_SW_STROBE && !out_q) out_q <= 1'b1;
                        if (pend_q) begin
                            cnt_q  <= reload_q;
                            run_q  <= 1'b1;
                            pend_q <= 1'b0;
                        end else if (run_q && gate_i) begin
                            cnt_q <= dec1;
                            if (dec1 == '0) begin
                                run_q <= 1'b0;
                                out_q <= (mode_q == M_TC_INT);
                            end
                        end
                    end
                    M_ONESHOT, M_HW_STROBE: begin
                        if (mode_q == M_HW_STROBE && !out_q) out_q <= 1'b1;
                        if (trig_now && armed_q) begin
                            cnt_q <= reload_q;
                            run_q <= 1'b1;
                            if (mode_q == M_ONESHOT) out_q <= 1'b0;
                        end else if (run_q) begin
                            cnt_q <= dec1;
                            if (dec1 == '0) begin
                                run_q <= 1'b0;
                                out_q <= (mode_q == M_ONESHOT);
                            end
                        end
                    end
                    M_RATE: begin
                        if (pend_q || (trig_now && armed_q)) begin
                            cnt_q  <= reload_q;
                            run_q  <= 1'b1;
                            pend_q <= 1'b0;
                            out_q  <= 1'b1;
                        end else if (run_q && gate_i) begin
                            if (cnt_q == ONE) begin
                                cnt_q <= reload_q;
                                out_q <= 1'b1;
                            end else begin
                                cnt_q <= dec1;
                                if (dec1 == ONE) out_q <= 1'b0;
                            end
                        end
                    end
                    M_SQUARE: begin
                        if (pend_q || (trig_now && armed_q)) begin
                            cnt_q  <= reload_q;
                            run_q  <= 1'b1;
                            pend_q <= 1'b0;
                            out_q  <= 1'b1;
                        end else if (run_q && gate_i) begin
                            if (cnt_q[0]) begin
                                cnt_q <= dec1;
                            end else if (cnt_q == TWO) begin
                                out_q <= !out_q;
                                cnt_q <= out_q ? reload_even : reload_q;
                            end else begin
                                cnt_q <= dec2;
                            end
                        end
                    end
                    default: ;
                endcase
            end
            if (rate_mode && !gate_i) out_q <= 1'b1;
            if (ld_i) begin
                reload_q <= ld_val_i;
                armed_q  <= 1'b1;
                if (restart_mode) pend_q <= 1'b1;
                if (mode_q == M_TC_INT) out_q <= 1'b0;
            end
        end
    end

    assign cnt_o = cnt_q;
    assign out_o = out_q;

    // R3: in mode 0 a high OUT only falls on a new count or control word
    a_r3_tc_out_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_TC_INT && out_q && !cw_wr_i && !ld_i) |=> out_q);

    // R4: a step with GATE low does not change a mode 0 count
    a_r4_gate_holds_count: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_TC_INT && tick_i && !gate_i && !pend_q && !cw_wr_i) |=> $stable(cnt_q));

    // R6: GATE low forces OUT high in the periodic modes
    a_r6_gate_low_out_high: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_mode && !gate_i && !cw_wr_i) |=> out_q);

    // R8: the software strobe lasts a single step
    a_r8_strobe_one_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_SW_STROBE && tick_i && !out_q && !cw_wr_i) |=> out_q);
endmodule

// File: rtl/pitc_channel.sv
// Top of one interval counter channel: edge detection on the counter
// clock and GATE, processor register access, and the counting engine.
// Assumes tmr_clk and gate are synchronous to clk and tmr_clk is much
// slower than clk (each level lasts at least one clk cycle).
module pitc_channel
    import pitc_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic             reg_sel,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rdata,
    input  logic             tmr_clk,
    input  logic             gate,
    output logic             out
);
    logic             tick, gate_rise, cw_wr, cw_bcd, ld;
    mode_t            cw_mode;
    logic [CNT_W-1:0] ld_val, cnt;

    pitc_edge #(.RISE(1'b0)) u_tick_det (.clk(clk), .rst_n(rst_n), .sig_i(tmr_clk), .edge_o(tick));
    pitc_edge #(.RISE(1'b1)) u_gate_det (.clk(clk), .rst_n(rst_n), .sig_i(gate), .edge_o(gate_rise));

    pitc_bus #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_bus (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .reg_sel(reg_sel),
        .wdata(wdata), .rdata(rdata), .cnt_i(cnt), .cw_wr_o(cw_wr), .cw_mode_o(cw_mode),
        .cw_bcd_o(cw_bcd), .ld_o(ld), .ld_val_o(ld_val)
    );

    pitc_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .gate_i(gate), .gate_rise_i(gate_rise),
        .cw_wr_i(cw_wr), .cw_mode_i(cw_mode), .cw_bcd_i(cw_bcd), .ld_i(ld),
        .ld_val_i(ld_val), .cnt_o(cnt), .out_o(out)
    );
endmodule

// File: tb/pitc_channel_bench.sv
module pitc_channel_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, reg_sel = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       tmr_clk = 1'b0, gate = 1'b1;
    logic       out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    pitc_channel u_pitc_channel (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .reg_sel(reg_sel),
        .wdata(wdata), .rdata(rdata), .tmr_clk(tmr_clk), .gate(gate), .out(out)
    );

    typedef struct packed {
        logic [2:0]  mode;
        logic        bcd;
        logic [15:0] n;
        logic [7:0]  hi;
        logic [7:0]  lo;
    } vec_t;

    // periodic-mode table: expected high/low phase lengths in steps (R6, R7)
    localparam vec_t TBL [0:6] = '{
        '{3'd2, 1'b0, 16'd5,     8'd4,  8'd1},
        '{3'd2, 1'b0, 16'd2,     8'd1,  8'd1},
        '{3'd3, 1'b0, 16'd4,     8'd2,  8'd2},
        '{3'd3, 1'b0, 16'd5,     8'd3,  8'd2},
        '{3'd3, 1'b0, 16'd7,     8'd4,  8'd3},
        '{3'd3, 1'b1, 16'h0011,  8'd6,  8'd5},
        '{3'd2, 1'b1, 16'h0012,  8'd11, 8'd1}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        reg_sel = sel; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd8(output logic [7:0] b);
        @(negedge clk);
        reg_sel = 1'b0; rd_en = 1'b1;
        #1 b = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rd16(output logic [15:0] v);
        logic [7:0] lo, hi;
        rd8(lo);
        rd8(hi);
        v = {hi, lo};
    endtask

    task automatic load(input logic [15:0] v);
        wr(1'b0, v[7:0]);
        wr(1'b0, v[15:8]);
    endtask

    task automatic tick();
        @(negedge clk) tmr_clk = 1'b1;
        @(negedge clk) tmr_clk = 1'b0;
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic setgate(input logic v);
        @(negedge clk) gate = v;
        @(negedge clk);
    endtask

    task automatic measure(input logic target, output int n);
        n = 0;
        while (out !== target && n < 300) begin
            tick();
            n++;
        end
    endtask

    initial begin
        #600000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R1 watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 out after reset", {15'd0, out}, 16'd1);
        rd16(v);
        chk("R1 count after reset", v, 16'h0000);

        // R6 R7 table of periodic waveforms
        for (int k = 0; k < 7; k++) begin
            wr(1'b1, {4'b0, TBL[k].bcd, TBL[k].mode});
            load(TBL[k].n);
            tick();
            measure(1'b0, n);
            chk($sformatf("R7 R6 row%0d high", k), 16'(n), {8'd0, TBL[k].hi});
            measure(1'b1, n);
            chk($sformatf("R7 R6 row%0d low", k), 16'(n), {8'd0, TBL[k].lo});
            measure(1'b0, n);
            chk($sformatf("R7 R6 row%0d high again", k), 16'(n), {8'd0, TBL[k].hi});
        end

        // R2 R3 R4 mode 0 with gate hold
        wr(1'b1, 8'h00);
        chk("R2 mode0 control write drives out low", {15'd0, out}, 16'd0);
        load(16'd3);
        tick();
        tick();
        setgate(1'b0);
        ticks(2);
        rd16(v);
        chk("R4 count held with gate low", v, 16'd2);
        setgate(1'b1);
        tick();
        chk("R3 out low before terminal count", {15'd0, out}, 16'd0);
        tick();
        chk("R3 out high at terminal count", {15'd0, out}, 16'd1);
        tick();
        chk("R3 out stays high", {15'd0, out}, 16'd1);
        rd16(v);
        chk("R3 count stopped at zero", v, 16'd0);

        // R8 software strobe
        wr(1'b1, 8'h04);
        chk("R2 mode4 control write drives out high", {15'd0, out}, 16'd1);
        load(16'd2);
        ticks(2);
        chk("R8 out high before strobe", {15'd0, out}, 16'd1);
        tick();
        chk("R8 strobe low", {15'd0, out}, 16'd0);
        tick();
        chk("R8 strobe ends after one step", {15'd0, out}, 16'd1);

        // R5 retriggerable one-shot
        wr(1'b1, 8'h01);
        load(16'd3);
        tick();
        chk("R5 no trigger keeps out high", {15'd0, out}, 16'd1);
        setgate(1'b0);
        setgate(1'b1);
        tick();
        chk("R5 trigger drives out low", {15'd0, out}, 16'd0);
        ticks(2);
        setgate(1'b0);
        setgate(1'b1);
        tick();
        ticks(2);
        chk("R5 retrigger extends low", {15'd0, out}, 16'd0);
        tick();
        chk("R5 out high after reloaded count", {15'd0, out}, 16'd1);

        // R9 hardware strobe
        wr(1'b1, 8'h05);
        load(16'd2);
        ticks(2);
        chk("R9 waits for gate rise", {15'd0, out}, 16'd1);
        setgate(1'b0);
        setgate(1'b1);
        ticks(2);
        chk("R9 out high while counting", {15'd0, out}, 16'd1);
        tick();
        chk("R9 strobe low", {15'd0, out}, 16'd0);
        tick();
        chk("R9 strobe ends", {15'd0, out}, 16'd1);

        // R10 zero as largest count, BCD borrow
        wr(1'b1, 8'h00);
        load(16'h0000);
        ticks(2);
        rd16(v);
        chk("R10 binary zero wraps", v, 16'hFFFF);
        wr(1'b1, 8'h08);
        load(16'h0000);
        ticks(2);
        rd16(v);
        chk("R10 bcd zero wraps", v, 16'h9999);
        wr(1'b1, 8'h08);
        load(16'h1000);
        ticks(2);
        rd16(v);
        chk("R10 bcd digit borrow", v, 16'h0999);

        // R11 latch command
        wr(1'b1, 8'h02);
        load(16'h0100);
        ticks(2);
        wr(1'b1, 8'h80);
        ticks(3);
        rd16(v);
        chk("R11 latched copy", v, 16'h00FF);
        rd16(v);
        chk("R11 live count after copy read", v, 16'h00FC);

        // R12 control word discards a half-written count
        wr(1'b1, 8'h00);
        wr(1'b0, 8'h05);
        wr(1'b1, 8'h00);
        load(16'd7);
        tick();
        rd16(v);
        chk("R12 sequencer reset by control word", v, 16'd7);

        // R6 gate control in mode 2
        wr(1'b1, 8'h02);
        load(16'd3);
        ticks(3);
        chk("R6 low pulse at count one", {15'd0, out}, 16'd0);
        setgate(1'b0);
        chk("R6 gate low forces out high", {15'd0, out}, 16'd1);
        setgate(1'b1);
        tick();
        rd16(v);
        chk("R6 gate rise reloads", v, 16'd3);

        // R2 code 6 acts as mode 2
        wr(1'b1, 8'h06);
        load(16'd3);
        ticks(3);
        chk("R2 code6 pulses like mode2", {15'd0, out}, 16'd0);
        tick();
        chk("R2 code6 pulse ends", {15'd0, out}, 16'd1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule